// File: doc/BRIEF.md
# Inbound Bus Window Decoder

This block sits behind the slave side of a backplane bus interface. It decides whether an incoming bus cycle belongs to local memory and, if so, which of several identical slave images claims it. Each image has a control word, a base word and a bound word. Software reaches them through a simple register port. The base and bound words hold the upper twenty address bits, so windows are placed and sized in 4 KB pages.

For every cycle request the decoder takes in the address, the access class (program or data, supervisor or user) and the direction. It filters the images by enable, window range, access class and privilege. The lowest-numbered image that matches wins. The decision is registered and appears one clock after the request strobe, together with whether the winning image allows a posted write (for writes) or a prefetched read (for reads). No image claims anything while the master-enable input is low.

A two-state machine carries the decision. In `ST_IDLE` no claim is presented. The transition `IDLE_TO_CLAIM` (or `CLAIM_TO_CLAIM`) is taken on a clock where a request is present, the master enable is high and at least one image matches. The transition `CLAIM_TO_IDLE` (or `IDLE_TO_IDLE`) is taken on any other clock. In `ST_CLAIM` the outputs present the winner captured on that edge.

Top module: `svwin_decoder`

## Requirements
- R1: The registers for image i sit at byte offsets 0xF00+16*i (control), +4 (base) and +8 (bound). Control keeps only bit 31 (enable), bit 30 (posted write), bit 29 (prefetch), bits 23:22 (class) and bit 20 (supervisor-only), and reads every other bit as zero. Base and bound keep bits 31:12 and read bits 11:0 as zero. Any other offset reads zero and ignores writes.
- R2: After reset every register reads zero and `hit_valid`, `hit_idx`, `hit_posted` and `hit_prefetch` are zero.
- R3: An image's window holds a cycle when base[31:12] <= address[31:12] < bound[31:12]. When bound <= base the window is empty.
- R4: An image whose enable bit (control bit 31) is clear never claims a cycle.
- R5: The class field (control bits 23:22) behaves as follows: 00 matches nothing, 01 matches data cycles only (`cyc_prog`=0), 10 matches program cycles only (`cyc_prog`=1), and 11 matches both.
- R6: When the supervisor-only bit (control bit 20) is set, user cycles (`cyc_super`=0) are rejected. When it is clear, both modes are accepted.
- R7: While `mst_en` is low at the request, no cycle is claimed.
- R8: When several images match, `hit_idx` is the lowest-numbered one.
- R9: `hit_posted` equals the winner's posted-write bit for write cycles and is 0 for reads. `hit_prefetch` equals the winner's prefetch bit for read cycles and is 0 for writes.
- R10: Outputs appear on the clock edge after the `cyc_req` cycle and last one cycle. Without a request, `hit_valid` is 0 and the other outputs are 0.
- R11: A register write is used by a cycle request presented in the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mst_en | input | 1 | Downstream master enable; gates all claims |
| cyc_req | input | 1 | Incoming cycle request strobe |
| cyc_addr | input | 32 | Incoming cycle address |
| cyc_prog | input | 1 | 1 = program access, 0 = data access |
| cyc_super | input | 1 | 1 = supervisor, 0 = user |
| cyc_write | input | 1 | 1 = write, 0 = read |
| hit_valid | output | 1 | Cycle claimed |
| hit_idx | output | 3 | Index of the claiming image |
| hit_posted | output | 1 | Posted write allowed for this claim |
| hit_prefetch | output | 1 | Read prefetch allowed for this claim |

## Verification
The bench sweeps pages across each window's edges. A decoder with `<=` on the bound, or one that skips the empty-window check, would claim the page at the bound or claim every page when bound <= base. It walks all class codes, privilege modes, directions and supervisor-only settings, which exposes a reserved code that matches, swapped class bits, or an inverted privilege check. Overlapping windows, compared before and after the lowest one is disabled, catch a priority encoder that picks the highest index. The master-enable sweep and the permission combinations catch posted or prefetch flags that leak onto the wrong direction.

// File: rtl/svwin_pkg.sv
package svwin_pkg;

    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;

    localparam int CTL_EN  = 31;
    localparam int CTL_PW  = 30;
    localparam int CTL_PF  = 29;
    localparam int CTL_CLH = 23;
    localparam int CTL_CLL = 22;
    localparam int CTL_SUP = 20;

    typedef struct packed {
        logic       en;
        logic       pw;
        logic       pf;
        logic [1:0] cls;
        logic       sup_only;
    } img_ctrl_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_CLAIM = 1'b1
    } dec_state_e;

    function automatic img_ctrl_t ctrl_unpack(input logic [31:0] w);
        img_ctrl_t c;
        c.en       = w[CTL_EN];
        c.pw       = w[CTL_PW];
        c.pf       = w[CTL_PF];
        c.cls      = w[CTL_CLH:CTL_CLL];
        c.sup_only = w[CTL_SUP];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input img_ctrl_t c);
        logic [31:0] w;
        w                 = '0;
        w[CTL_EN]         = c.en;
        w[CTL_PW]         = c.pw;
        w[CTL_PF]         = c.pf;
        w[CTL_CLH:CTL_CLL] = c.cls;
        w[CTL_SUP]        = c.sup_only;
        return w;
    endfunction

endpackage

// File: rtl/svwin_regs.sv
module svwin_regs
    import svwin_pkg::*;
#(
    parameter int          NUM_IMG  = 8,
    parameter logic [11:0] REG_BASE = 12'hF00,
    parameter int          STRIDE   = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [11:0]                      reg_addr,
    input  logic [31:0]                      reg_wdata,
    output logic [31:0]                      reg_rdata,
    output img_ctrl_t [NUM_IMG-1:0]          ctrl_o,
    output logic [NUM_IMG-1:0][PAGE_W-1:0]   base_o,
    output logic [NUM_IMG-1:0][PAGE_W-1:0]   bound_o
);

    localparam int IDX_W    = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1;
    localparam int STR_LSB  = $clog2(STRIDE);
    localparam int SPAN     = NUM_IMG * STRIDE;

    logic [11:0]      off;
    logic             in_rng;
    logic [IDX_W-1:0] img_sel;
    logic [1:0]       word_sel;

    assign off      = reg_addr - REG_BASE;
    assign in_rng   = (reg_addr >= REG_BASE) && (int'(off) < SPAN);
    assign img_sel  = off[STR_LSB +: IDX_W];
    assign word_sel = off[3:2];

    for (genvar i = 0; i < NUM_IMG; i++) begin : g_img
        logic sel;
        assign sel = reg_we && in_rng && (int'(img_sel) == i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_o[i]  <= '0;
                base_o[i]  <= '0;
                bound_o[i] <= '0;
            end else if (sel) begin
                unique case (word_sel)
                    2'd0:    ctrl_o[i]  <= ctrl_unpack(reg_wdata);
                    2'd1:    base_o[i]  <= reg_wdata[ADDR_W-1:PAGE_LSB];
                    2'd2:    bound_o[i] <= reg_wdata[ADDR_W-1:PAGE_LSB];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_rng) begin
            unique case (word_sel)
                2'd0:    reg_rdata = ctrl_pack(ctrl_o[img_sel]);
                2'd1:    reg_rdata = {base_o[img_sel], {PAGE_LSB{1'b0}}};
                2'd2:    reg_rdata = {bound_o[img_sel], {PAGE_LSB{1'b0}}};
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/svwin_match.sv
module svwin_match
    import svwin_pkg::*;
(
    input  img_ctrl_t         ctrl,
    input  logic [PAGE_W-1:0] base,
    input  logic [PAGE_W-1:0] bound,
    input  logic [PAGE_W-1:0] page,
    input  logic              prog,
    input  logic              super_mode,
    output logic              hit
);

    logic in_win;
    logic cls_ok;
    logic priv_ok;

    assign in_win  = (page >= base) && (page < bound);
    assign cls_ok  = prog ? ctrl.cls[1] : ctrl.cls[0];
    assign priv_ok = !ctrl.sup_only || super_mode;
    assign hit     = ctrl.en && in_win && cls_ok && priv_ok;

endmodule

// File: rtl/svwin_prio.sv
module svwin_prio #(
    parameter int NUM_IMG = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_IMG-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_IMG - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end

    assign any = |hits;

endmodule

// File: rtl/svwin_decoder.sv
module svwin_decoder
    import svwin_pkg::*;
#(
    parameter int          NUM_IMG  = 8,
    parameter logic [11:0] REG_BASE = 12'hF00,
    localparam int         IDX_W    = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              mst_en,
    input  logic              cyc_req,
    input  logic [31:0]       cyc_addr,
    input  logic              cyc_prog,
    input  logic              cyc_super,
    input  logic              cyc_write,
    output logic              hit_valid,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              hit_posted,
    output logic              hit_prefetch
);

    img_ctrl_t [NUM_IMG-1:0]        ctrl;
    logic [NUM_IMG-1:0][PAGE_W-1:0] base;
    logic [NUM_IMG-1:0][PAGE_W-1:0] bound;
    logic [NUM_IMG-1:0]             hits;
    logic                           any_hit;
    logic [IDX_W-1:0]               win_idx;
    logic [PAGE_W-1:0]              page;

    dec_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             pw_q, pf_q;

    svwin_regs #(
        .NUM_IMG  (NUM_IMG),
        .REG_BASE (REG_BASE),
        .STRIDE   (16)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl_o    (ctrl),
        .base_o    (base),
        .bound_o   (bound)
    );

    assign page = cyc_addr[ADDR_W-1:PAGE_LSB];

    for (genvar i = 0; i < NUM_IMG; i++) begin : g_match
        svwin_match u_match (
            .ctrl       (ctrl[i]),
            .base       (base[i]),
            .bound      (bound[i]),
            .page       (page),
            .prog       (cyc_prog),
            .super_mode (cyc_super),
            .hit        (hits[i])
        );
    end

    svwin_prio #(
        .NUM_IMG (NUM_IMG),
        .IDX_W   (IDX_W)
    ) u_prio (
        .hits (hits),
        .any  (any_hit),
        .idx  (win_idx)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = (cyc_req && mst_en && any_hit) ? ST_CLAIM : ST_IDLE;
            ST_CLAIM: state_d = (cyc_req && mst_en && any_hit) ? ST_CLAIM : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            pw_q  <= 1'b0;
            pf_q  <= 1'b0;
        end else if (state_d == ST_CLAIM) begin
            idx_q <= win_idx;
            pw_q  <= ctrl[win_idx].pw && cyc_write;
            pf_q  <= ctrl[win_idx].pf && !cyc_write;
        end else begin
            idx_q <= '0;
            pw_q  <= 1'b0;
            pf_q  <= 1'b0;
        end
    end

    assign hit_valid    = (state_q == ST_CLAIM);
    assign hit_idx      = idx_q;
    assign hit_posted   = pw_q;
    assign hit_prefetch = pf_q;

endmodule

// File: rtl/svwin_decoder_chk.sv
module svwin_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_req,
    input logic cyc_write,
    input logic mst_en,
    input logic hit_valid,
    input logic hit_posted,
    input logic hit_prefetch
);

    // R10
    claim_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(cyc_req));

    // R7
    claim_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(mst_en));

    // R9
    posted_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_posted |-> (hit_valid && $past(cyc_write)));

    // R9
    prefetch_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_prefetch |-> (hit_valid && !$past(cyc_write)));

    // R10
    claim_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !cyc_req) |=> !hit_valid);

    // R2
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!hit_valid && !hit_posted && !hit_prefetch);
        end
    end

endmodule

bind svwin_decoder svwin_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_req      (cyc_req),
    .cyc_write    (cyc_write),
    .mst_en       (mst_en),
    .hit_valid    (hit_valid),
    .hit_posted   (hit_posted),
    .hit_prefetch (hit_prefetch)
);

// File: tb/svwin_decoder_tb.sv
module svwin_decoder_tb_top;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mst_en = 1'b0;
    logic        cyc_req = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        cyc_prog = 1'b0;
    logic        cyc_super = 1'b0;
    logic        cyc_write = 1'b0;
    logic        hit_valid;
    logic [2:0]  hit_idx;
    logic        hit_posted;
    logic        hit_prefetch;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_ctrl  [N];
    logic [19:0] m_base  [N];
    logic [19:0] m_bound [N];

    always #10 clk = ~clk;

    svwin_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mst_en(mst_en),
        .cyc_req(cyc_req), .cyc_addr(cyc_addr), .cyc_prog(cyc_prog),
        .cyc_super(cyc_super), .cyc_write(cyc_write), .hit_valid(hit_valid),
        .hit_idx(hit_idx), .hit_posted(hit_posted), .hit_prefetch(hit_prefetch)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int img, input int word, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 12'(12'hF00 + img * 16 + word * 4);
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (word == 0) m_ctrl[img]  = d & 32'hE0D0_0000;
        if (word == 1) m_base[img]  = d[31:12];
        if (word == 2) m_bound[img] = d[31:12];
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic set_img(input int img, input logic [31:0] c, input int b, input int bd);
        wr_reg(img, 1, 32'(b) << 12);
        wr_reg(img, 2, 32'(bd) << 12);
        wr_reg(img, 0, c);
    endtask

    // expected decode, from the requirements
    task automatic model(input logic [31:0] a, input logic p, input logic s, input logic w,
                         input logic me, output logic [5:0] exp);
        logic v;
        int   win;
        v   = 1'b0;
        win = 0;
        for (int i = N - 1; i >= 0; i--) begin
            logic [19:0] pg;
            logic ok;
            pg = a[31:12];
            ok = m_ctrl[i][31] && (pg >= m_base[i]) && (pg < m_bound[i])
                 && (p ? m_ctrl[i][23] : m_ctrl[i][22])
                 && (!m_ctrl[i][20] || s);
            if (ok) begin v = 1'b1; win = i; end
        end
        v = v && me;
        if (v) exp = {v, 3'(win), m_ctrl[win][30] && w, m_ctrl[win][29] && !w};
        else   exp = '0;
    endtask

    task automatic cyc(input string req, input logic [31:0] a, input logic p,
                       input logic s, input logic w);
        logic [5:0] e;
        model(a, p, s, w, mst_en, e);
        @(negedge clk);
        cyc_req = 1'b1; cyc_addr = a; cyc_prog = p; cyc_super = s; cyc_write = w;
        @(negedge clk);
        cyc_req = 1'b0;
        chk(req, {26'd0, hit_valid, hit_idx, hit_posted, hit_prefetch}, {26'd0, e});
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_ctrl[i] = '0; m_base[i] = '0; m_bound[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 outputs", {28'd0, hit_valid, hit_posted, hit_prefetch, |hit_idx}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            rd_chk("R2 ctrl", 12'(12'hF00 + i * 16), 32'd0);
            rd_chk("R2 base", 12'(12'hF04 + i * 16), 32'd0);
            rd_chk("R2 bound", 12'(12'hF08 + i * 16), 32'd0);
        end
        mst_en = 1'b1;

        // R1 register layout and masking
        wr_reg(3, 0, 32'hFFFF_FFFF);
        rd_chk("R1 ctrl mask", 12'hF30, 32'hE0D0_0000);
        wr_reg(3, 1, 32'h1234_5FFF);
        rd_chk("R1 base mask", 12'hF34, 32'h1234_5000);
        wr_reg(3, 2, 32'hFEDC_BABC);
        rd_chk("R1 bound mask", 12'hF38, 32'hFEDC_B000);
        @(negedge clk); reg_we = 1'b1; reg_addr = 12'hF3C; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); reg_we = 1'b0;
        rd_chk("R1 gap reads zero", 12'hF3C, 32'd0);
        @(negedge clk); reg_we = 1'b1; reg_addr = 12'hE00; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); reg_we = 1'b0;
        rd_chk("R1 below range", 12'hE00, 32'd0);
        rd_chk("R1 above range", 12'hF80, 32'd0);
        for (int i = 0; i < N; i++) if (i != 3)
            rd_chk("R1 no stray write", 12'(12'hF00 + i * 16), 32'd0);
        set_img(3, 32'd0, 0, 0);

        // R10: idle without request
        repeat (3) begin
            @(negedge clk);
            chk("R10 idle", {31'd0, hit_valid}, 32'd0);
        end

        // R3 window edges, R11 write then immediate use
        set_img(0, 32'h80C0_0000, 5, 9);
        cyc("R11 first cycle after write", 32'h0000_5000, 1'b0, 1'b1, 1'b0);
        for (int pg = 0; pg < 16; pg++)
            cyc("R3 window sweep", (32'(pg) << 12) | 32'hABC, pg[0], 1'b0, pg[1]);
        // R10: one-cycle claim
        cyc("R10 claim", 32'h0000_6000, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R10 single cycle", {31'd0, hit_valid}, 32'd0);
        wr_reg(0, 2, 32'h0000_5000);
        for (int pg = 0; pg < 16; pg++)
            cyc("R3 empty equal", 32'(pg) << 12, 1'b0, 1'b1, 1'b0);
        wr_reg(0, 2, 32'h0000_3000);
        for (int pg = 0; pg < 16; pg++)
            cyc("R3 empty inverted", 32'(pg) << 12, 1'b1, 1'b1, 1'b1);
        cyc("R3 top page", 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);
        set_img(0, 32'h80C0_0000, 20'hFFFF0, 20'hFFFFF);
        cyc("R3 high window", 32'hFFFF_E000, 1'b0, 1'b1, 1'b0);
        cyc("R3 high bound excl", 32'hFFFF_F000, 1'b0, 1'b1, 1'b0);

        // R4 R5 R6 R9 class, privilege, direction, enable sweep
        for (int m = 0; m < 256; m++) begin
            logic [31:0] c;
            c = {m[0], m[1], m[2], 6'd0, m[4:3], 1'b0, m[5], 20'd0};
            set_img(0, c, 0, 32);
            cyc("R4 R5 R6 R9 class sweep", 32'h0001_0000, m[6], m[7], m[1]);
        end

        // R8 priority among overlaps
        set_img(0, 32'h0000_0000, 0, 0);
        set_img(2, 32'h80C0_0000, 4, 20);
        set_img(5, 32'hE0C0_0000, 0, 32);
        set_img(6, 32'hA0C0_0000, 10, 12);
        for (int pg = 0; pg < 40; pg++)
            cyc("R8 overlap", 32'(pg) << 12, 1'b0, 1'b1, pg[0]);
        wr_reg(2, 0, 32'h0000_0000);
        for (int pg = 0; pg < 40; pg++)
            cyc("R8 after disable", 32'(pg) << 12, 1'b1, 1'b0, pg[0]);

        // R9 permission combinations on image 5
        for (int k = 0; k < 8; k++) begin
            wr_reg(5, 0, {1'b1, k[0], k[1], 6'd0, 2'b11, 22'd0});
            cyc("R9 perms", 32'h0000_1000, 1'b0, 1'b1, k[2]);
        end

        // R7 master enable
        mst_en = 1'b0;
        for (int pg = 0; pg < 16; pg++)
            cyc("R7 master off", 32'(pg) << 12, 1'b0, 1'b1, pg[0]);
        mst_en = 1'b1;
        cyc("R7 master on", 32'h0000_1000, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule